// File: doc/BRIEF.md
# Smart Card Contact Supply Sequencer

This block stands between a host controller and the contact interface of a smart card. It turns three host control levels (an emergency halt, a supply level choice and a power request) into a supply enable, a latched supply level, a contact pull-down enable, and gated copies of the host reset, clock and data lines for the card. Powering the card is refused while the emergency halt is low. Deactivation always takes the contacts down in a fixed order before the supply is removed. A minimum off-time must pass before the supply may return.

All timing comes from a down counter clocked by the system clock. The settling delay, the hold-off time and the length of each deactivation step are parameters, given in microseconds or in cycles. A power request raised during the hold-off is not lost: it is served once the off-time has elapsed. A status output exposes the sequencer state so that the order of events can be watched from outside.

Top module: `card_supply_seq`

## Requirements
- R1: A low `halt_n` takes an activating or active card into deactivation at the next clock. While `halt_n` stays low, the supply is never switched on, whatever `power_req_i` does.
- R2: With `halt_n` high and `power_req_i` low the block is powered down: the supply is off, all three card lines are low, and `lowv_sel_i` is captured into `supply_vsel_o` (0 = higher 5 V level, 1 = lower 3 V level).
- R3: In the active state the card reset, clock and data lines equal the host reset, clock and data lines, and the supply is on.
- R4: While the supply is on, `supply_vsel_o` does not change. A new level set on `lowv_sel_i` only takes effect after a deactivation and a new activation.
- R5: After reset the state is off (code 0), the supply is off, the 5 V level is selected (`supply_vsel_o` = 0), `ready_o` is low and the pull-down is enabled.
- R6: Deactivation drives card reset low at once. The card clock goes low STEP_CYCLES cycles later and card data 2·STEP_CYCLES cycles later. The supply goes off 3·STEP_CYCLES cycles after deactivation starts.
- R7: If the host clock is already low in the last cycle of the reset step, the clock step is skipped. Data then goes low after STEP_CYCLES cycles and the supply goes off after 2·STEP_CYCLES cycles.
- R8: After the supply goes off, the hold-off state lasts exactly HOLDOFF_US·CLK_HZ/10^6 cycles, and the off state follows for one cycle. A request raised during the hold-off then starts activation.
- R9: Activation lasts exactly SETTLE_US·CLK_HZ/10^6 cycles with the supply on, all card lines low and `ready_o` low. The active state follows, with `ready_o` high.
- R10: `pulldown_en_o` is high in every state except activating and active.
- R11: `state_o` encodes off = 0, activating = 1, active = 2, deactivating = 3, hold-off = 4. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| halt_n | input | 1 | Emergency halt, active low |
| lowv_sel_i | input | 1 | Supply level choice: 0 = 5 V, 1 = 3 V |
| power_req_i | input | 1 | Host request to power the card |
| host_rst_i | input | 1 | Host reset line for the card |
| host_clk_i | input | 1 | Host clock line for the card |
| host_io_i | input | 1 | Host data drive for the card |
| card_rst_o | output | 1 | Gated reset towards the card |
| card_clk_o | output | 1 | Gated clock towards the card |
| card_io_o | output | 1 | Gated data drive towards the card |
| supply_en_o | output | 1 | Card supply enable |
| supply_vsel_o | output | 1 | Latched supply level: 0 = 5 V, 1 = 3 V |
| pulldown_en_o | output | 1 | Active contact pull-down enable |
| ready_o | output | 1 | Card supply settled and contacts live |
| state_o | output | 3 | Sequencer state code |

## Verification
On every cycle the assertions check several invariants. The latched level stays frozen while powered, and the supply never rises before the off-time has been counted. Card reset stays low throughout deactivation, and the clock stays low after the reset step. All three lines are low at the moment the supply drops, a low halt in an unpowered state keeps the supply off, and the ready flag implies a powered card without pull-down. The exact step lengths, the skipped clock step, the one-cycle off state before a pending request is served, and the capture of a new level only across a power cycle appear only in the bench's directed and random scenarios, which time each state from the status output.

// File: rtl/card_seq_pkg.sv
`timescale 1ns/1ps
package card_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_RAMP = 3'd1,
    ST_LIVE = 3'd2,
    ST_WIND = 3'd3,
    ST_REST = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    WD_RST = 2'd0,
    WD_CLK = 2'd1,
    WD_IO  = 2'd2
  } wind_step_e;

  localparam int LANES  = 3;
  localparam int LN_RST = 0;
  localparam int LN_CLK = 1;
  localparam int LN_IO  = 2;

  function automatic int usec_to_cycles(input int hz, input int us);
    longint prod;
    prod = longint'(hz) * longint'(us);
    return int'(prod / 64'sd1000000);
  endfunction

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seq_down_timer.sv
`timescale 1ns/1ps
module seq_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

  // Timing base for R6, R8 and R9: one count per cycle, and it rests at zero.
  p_timer_steps_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_timer_rests_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && expired_o) |=> expired_o);

endmodule

// File: rtl/card_vsel_hold.sv
`timescale 1ns/1ps
module card_vsel_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_i,
  input  logic powered_i,
  input  logic sel_i,
  output logic sel_o
);

  logic sel_q;
  logic sel_d;

  always_comb begin
    sel_d = sel_q;
    if (capture_i) begin
      sel_d = sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

  p_vsel_frozen_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    powered_i |=> $stable(sel_o));

  p_no_capture_powered_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    powered_i |-> !capture_i);

endmodule

// File: rtl/card_contact_gate.sv
`timescale 1ns/1ps
module card_contact_gate #(
  parameter int N = 3
) (
  input  logic [N-1:0] pass_i,
  input  logic [N-1:0] host_i,
  output logic [N-1:0] card_o
);

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign card_o[g] = pass_i[g] & host_i[g];
  end

endmodule

// File: rtl/card_supply_seq.sv
`timescale 1ns/1ps
module card_supply_seq import card_seq_pkg::*; #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int SETTLE_US   = 50_000,
  parameter int HOLDOFF_US  = 350_000,
  parameter int STEP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_n,
  input  logic       lowv_sel_i,
  input  logic       power_req_i,
  input  logic       host_rst_i,
  input  logic       host_clk_i,
  input  logic       host_io_i,
  output logic       card_rst_o,
  output logic       card_clk_o,
  output logic       card_io_o,
  output logic       supply_en_o,
  output logic       supply_vsel_o,
  output logic       pulldown_en_o,
  output logic       ready_o,
  output logic [2:0] state_o
);

  localparam int SETTLE_CYC = usec_to_cycles(CLK_HZ, SETTLE_US);
  localparam int HOLD_CYC   = usec_to_cycles(CLK_HZ, HOLDOFF_US);
  localparam int MAX_CYC    = max_of3(SETTLE_CYC, HOLD_CYC, STEP_CYCLES);
  localparam int TW         = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] HOLD_LD   = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] STEP_LD   = TW'(STEP_CYCLES - 1);
  localparam logic [TW-1:0] HOLD_MIN  = TW'(HOLD_CYC);

  seq_state_e state_q, state_d;
  wind_step_e step_q, step_d;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;
  logic          abort;
  logic          capture;
  logic          powered;
  logic [LANES-1:0] pass_en;
  logic [LANES-1:0] host_lines;
  logic [LANES-1:0] card_lines;

  assign abort = !halt_n || !power_req_i;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_OFF: begin
        if (halt_n && power_req_i) begin
          state_d  = ST_RAMP;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
        end
      end
      ST_RAMP: begin
        if (abort) begin
          state_d  = ST_WIND;
          step_d   = WD_RST;
          tmr_load = 1'b1;
          tmr_val  = STEP_LD;
        end else if (tmr_expired) begin
          state_d = ST_LIVE;
        end
      end
      ST_LIVE: begin
        if (abort) begin
          state_d  = ST_WIND;
          step_d   = WD_RST;
          tmr_load = 1'b1;
          tmr_val  = STEP_LD;
        end
      end
      ST_WIND: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          case (step_q)
            WD_RST: begin
              step_d  = host_clk_i ? WD_CLK : WD_IO;
              tmr_val = STEP_LD;
            end
            WD_CLK: begin
              step_d  = WD_IO;
              tmr_val = STEP_LD;
            end
            default: begin
              state_d = ST_REST;
              tmr_val = HOLD_LD;
            end
          endcase
        end
      end
      ST_REST: begin
        if (tmr_expired) begin
          state_d = ST_OFF;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      step_q  <= WD_RST;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  seq_down_timer #(.W(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_expired)
  );

  assign powered = (state_q == ST_RAMP) || (state_q == ST_LIVE) || (state_q == ST_WIND);
  assign capture = ((state_q == ST_OFF) || (state_q == ST_REST)) && halt_n && !power_req_i;

  card_vsel_hold u_vsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .powered_i (powered),
    .sel_i     (lowv_sel_i),
    .sel_o     (supply_vsel_o)
  );

  always_comb begin
    pass_en         = '0;
    pass_en[LN_RST] = (state_q == ST_LIVE);
    pass_en[LN_CLK] = (state_q == ST_LIVE) || ((state_q == ST_WIND) && (step_q == WD_RST));
    pass_en[LN_IO]  = (state_q == ST_LIVE) || ((state_q == ST_WIND) && (step_q != WD_IO));
  end

  always_comb begin
    host_lines         = '0;
    host_lines[LN_RST] = host_rst_i;
    host_lines[LN_CLK] = host_clk_i;
    host_lines[LN_IO]  = host_io_i;
  end

  card_contact_gate #(.N(LANES)) u_gate (
    .pass_i (pass_en),
    .host_i (host_lines),
    .card_o (card_lines)
  );

  assign card_rst_o    = card_lines[LN_RST];
  assign card_clk_o    = card_lines[LN_CLK];
  assign card_io_o     = card_lines[LN_IO];
  assign supply_en_o   = powered;
  assign pulldown_en_o = !((state_q == ST_RAMP) || (state_q == ST_LIVE));
  assign ready_o       = (state_q == ST_LIVE);
  assign state_o       = state_q;

  // Off-time monitor for the hold-off check
  logic [TW-1:0] off_run_q;
  logic          seen_on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run_q <= '0;
      seen_on_q <= 1'b0;
    end else if (supply_en_o) begin
      off_run_q <= '0;
      seen_on_q <= 1'b1;
    end else if (off_run_q < HOLD_MIN) begin
      off_run_q <= off_run_q + 1'b1;
    end
  end

  p_holdoff_kept_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(supply_en_o) && seen_on_q) |-> (off_run_q >= HOLD_MIN));

  p_halt_blocks_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_n && !supply_en_o) |=> !supply_en_o);

  p_halt_winds_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_n && ((state_q == ST_RAMP) || (state_q == ST_LIVE))) |=> (state_q == ST_WIND));

  p_reset_first_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WIND) |-> !card_rst_o);

  p_clock_second_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WIND) && (step_q != WD_RST)) |-> !card_clk_o);

  p_lines_low_at_cut_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en_o) |-> $past(!card_rst_o && !card_clk_o && !card_io_o));

  p_ready_powered_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (supply_en_o && !pulldown_en_o));

  p_pulldown_unpowered_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !supply_en_o |-> pulldown_en_o);

  p_state_code_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);

endmodule

// File: tb/sim_card_supply_seq.sv
`timescale 1ns/1ps
module sim_card_supply_seq;

  localparam int CLK_HZ     = 1_000_000;
  localparam int SETTLE_US  = 20;
  localparam int HOLDOFF_US = 40;
  localparam int STEP       = 3;

  function automatic int to_cyc(input int us);
    return (CLK_HZ / 1000000) * us;
  endfunction

  localparam int SETTLE = SETTLE_US;
  localparam int HOLD   = HOLDOFF_US;

  logic clk;
  logic rst_n, halt_n, lowv_sel, power_req;
  logic host_rst, host_clk, host_io;
  logic card_rst, card_clk, card_io;
  logic supply_en, supply_vsel, pulldown_en, ready;
  logic [2:0] state;

  int n_chk = 0;
  int n_err = 0;
  bit fin = 0;
  logic m_vsel;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  card_supply_seq #(
    .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .HOLDOFF_US(HOLDOFF_US), .STEP_CYCLES(STEP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .lowv_sel_i(lowv_sel),
    .power_req_i(power_req), .host_rst_i(host_rst), .host_clk_i(host_clk),
    .host_io_i(host_io), .card_rst_o(card_rst), .card_clk_o(card_clk),
    .card_io_o(card_io), .supply_en_o(supply_en), .supply_vsel_o(supply_vsel),
    .pulldown_en_o(pulldown_en), .ready_o(ready), .state_o(state)
  );

  // Requirement model of the latched level (R2, R4)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_vsel <= 1'b0;
    else if ((state == 3'd0 || state == 3'd4) && halt_n && !power_req) m_vsel <= lowv_sel;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nedge();
    @(negedge clk);
  endtask

  // Observes a full deactivation and hold-off, cycle by cycle.
  task automatic run_wind(input bit skip, input bit pend);
    int d;
    int h;
    d = (skip ? 2 : 3) * STEP;
    h = to_cyc(HOLDOFF_US);
    for (int n = 0; n <= d + h + 1; n++) begin
      nedge();
      if (n < d) begin
        chk("R6 state wind", state, 3);
        chk("R6 supply on", supply_en, 1);
        chk("R6 reset low", card_rst, 0);
        chk(skip ? "R7 clock" : "R6 clock", card_clk, skip ? 0 : int'(n < STEP));
        chk(skip ? "R7 data" : "R6 data", card_io, skip ? int'(n < STEP) : int'(n < 2 * STEP));
        chk("R10 pulldown wind", pulldown_en, 1);
      end else if (n < d + h) begin
        chk("R8 state rest", state, 4);
        chk("R8 supply off", supply_en, 0);
        chk("R10 pulldown rest", pulldown_en, 1);
      end else if (n == d + h) begin
        chk("R8 state off", state, 0);
      end else begin
        chk("R8 pending served", state, pend ? 1 : 0);
      end
      if (pend && n == d + 2) begin
        power_req = 1'b1;
        halt_n = 1'b1;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!fin) begin
      n_err++;
      $display("FAIL R11 watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed;
    int prev;
    int run;
    bit first;
    seed = $urandom(32'd1357);
    rst_n = 1'b0; halt_n = 1'b1; lowv_sel = 1'b0; power_req = 1'b0;
    host_rst = 1'b1; host_clk = 1'b1; host_io = 1'b1;
    repeat (3) nedge();
    chk("R5 state", state, 0);
    chk("R5 supply", supply_en, 0);
    chk("R5 level", supply_vsel, 0);
    chk("R5 ready", ready, 0);
    chk("R5 pulldown", pulldown_en, 1);
    chk("R5 lines", {card_rst, card_clk, card_io}, 0);
    rst_n = 1'b1;

    // R2: capture the lower level while unpowered
    lowv_sel = 1'b1;
    nedge(); nedge();
    chk("R2 level", supply_vsel, 1);
    chk("R2 supply", supply_en, 0);
    chk("R2 lines", {card_rst, card_clk, card_io}, 0);
    chk("R10 pulldown off", pulldown_en, 1);

    // R9: activation
    power_req = 1'b1;
    for (int n = 0; n <= SETTLE; n++) begin
      nedge();
      if (n < SETTLE) begin
        chk("R9 state ramp", state, 1);
        chk("R9 ready low", ready, 0);
        chk("R9 lines low", {card_rst, card_clk, card_io}, 0);
        chk("R9 supply", supply_en, 1);
        chk("R10 no pulldown ramp", pulldown_en, 0);
      end else begin
        chk("R11 state live", state, 2);
        chk("R9 ready high", ready, 1);
        chk("R3 lines follow", {card_rst, card_clk, card_io}, 7);
      end
    end

    // R3 pass-through, R4 level frozen while powered
    for (int k = 0; k < 8; k++) begin
      {host_rst, host_clk, host_io} = 3'(k);
      lowv_sel = k[0];
      #1;
      chk("R3 follow", {card_rst, card_clk, card_io}, k);
      chk("R4 level frozen", supply_vsel, 1);
      nedge();
    end
    lowv_sel = 1'b0;
    nedge();
    chk("R4 level frozen", supply_vsel, 1);

    // R6 ordered wind-down by request, R8 pending request served
    host_rst = 1'b1; host_clk = 1'b1; host_io = 1'b1;
    power_req = 1'b0;
    run_wind(1'b0, 1'b1);
    repeat (SETTLE) nedge();
    chk("R9 live again", state, 2);
    chk("R4 new level", supply_vsel, 0);

    // R1 halt with clock low, R7 clock step skipped
    host_clk = 1'b0;
    halt_n = 1'b0;
    run_wind(1'b1, 1'b0);
    repeat (10) begin
      nedge();
      chk("R1 halt holds off", state, 0);
      chk("R1 supply off", supply_en, 0);
    end
    halt_n = 1'b1;
    nedge();
    chk("R1 release", state, 1);
    halt_n = 1'b0;
    nedge();
    chk("R1 halt during ramp", state, 3);
    halt_n = 1'b1;
    power_req = 1'b0;
    repeat (2 * STEP + HOLD + 2) nedge();
    chk("R8 back off", state, 0);

    // Random phase
    first = 1'b1;
    prev = state;
    run = 0;
    for (int c = 0; c < 6000; c++) begin
      nedge();
      chk("R4 level model", supply_vsel, m_vsel);
      if (state > 3'd4) chk("R11 code", state, 0);
      if (state == 3'd2) begin
        chk("R3 follow", {card_rst, card_clk, card_io}, {host_rst, host_clk, host_io});
        chk("R3 supply", supply_en, 1);
      end
      if (state == 3'd0 || state == 3'd4) begin
        chk("R2 unpowered", {supply_en, card_rst, card_clk, card_io}, 0);
        chk("R10 pulldown", pulldown_en, 1);
      end
      if (state == 3'd1) chk("R9 ramp", {ready, card_rst, card_clk, card_io, supply_en}, 1);
      if (state == 3'd3) chk("R6 reset low", card_rst, 0);
      if (state != prev) begin
        if (!first) begin
          if (prev == 4) chk("R8 hold length", run, HOLD);
          if (prev == 1 && state == 2) chk("R9 settle length", run, SETTLE);
          if (prev == 3) chk("R6 wind length", int'(run == 2 * STEP || run == 3 * STEP), 1);
        end
        first = 1'b0;
        prev = state;
        run = 1;
      end else begin
        run++;
      end
      if ($urandom % 50 == 0) power_req = ~power_req;
      if ($urandom % 300 == 0) halt_n = ~halt_n;
      if ($urandom % 15 == 0) lowv_sel = ~lowv_sel;
      {host_rst, host_clk, host_io} = 3'($urandom);
    end

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule